// File: doc/BRIEF.md
# Vector Carry and Borrow Arithmetic Unit

This unit runs the element-wise add-with-carry and subtract-with-borrow operations of a vector instruction set. It also runs the two variants that produce a carry-out or borrow-out mask instead of a result element. A single instruction word comes in with a start pulse. The unit decodes it, samples the vector length, the maximum length, the element width and the register grouping factor, and then walks the elements one per cycle.

For each element the unit shows the element index on `elem_idx`. The surrounding register file answers in the same cycle with the vs2 element, the vs1 element and bit `elem_idx` of mask register v0. The unit then presents either a result element or a destination mask bit on its write port. Mask-producing operations can also sweep the tail, from vl up to vlmax-1, and write zero bits there.

The controller has four states. IDLE waits for `start`. On start it moves to DONE when the instruction is illegal, to RUN when vl is non-zero, to TAIL when vl is zero and a tail sweep is due, and to DONE otherwise. RUN writes one element per cycle. After the last body element it goes to TAIL when a tail sweep is due, or to DONE otherwise. TAIL writes one zero mask bit per cycle until vlmax-1 and then goes to DONE. DONE lasts one cycle, pulses `done` and returns to IDLE.

Top module: `vec_carry_unit`

## Requirements
- R1: Only major opcode 1010111 is accepted. Bits [31:26] select the operation: 010000 add-with-carry, 010001 carry-out mask, 010010 subtract-with-borrow, 010011 borrow-out mask. Bits [14:12] select the second operand: 000 vs1 element, 100 scalar, 011 immediate. Any other value, or the immediate form with either subtract operation, is flagged illegal.
- R2: Add-with-carry writes (vs2 + op1 + v0[i]) mod 2^SEW as the result element. Bits of `wr_data` above SEW are zero.
- R3: Subtract-with-borrow writes (vs2 - op1 - v0[i]) mod 2^SEW as the result element. Bits of `wr_data` above SEW are zero.
- R4: Carry-out mask writes 1 when the SEW-wide unsigned sum vs2 + op1 + cin overflows. cin is v0[i] when bit 25 (vm) is 0 and is 0 when vm is 1.
- R5: Borrow-out mask writes (vs2 <= op1) when the borrow-in is 1 and (vs2 < op1) when it is 0. Both comparisons are unsigned at SEW width. The borrow-in is chosen by vm in the same way as in R4.
- R6: The unit raises `illegal` with `done` and writes nothing in two cases. The first is add-with-carry or subtract-with-borrow with vm=1. The second is either of those operations with destination field [11:7] equal to 0 while `lmul` is 1, 2 or 3 (a group of 2, 4 or 8 registers).
- R7: `sew` codes 0..3 select 8, 16, 32 or 64 bits. The scalar is truncated to SEW. The 5-bit immediate in bits [19:15] is sign-extended to SEW.
- R8: Body writes cover indices 0..vl-1 in ascending order, one per consecutive cycle, with `busy` high throughout.
- R9: When `tail_agn` is 1, the mask operations also write a 0 bit for each index from vl to vlmax-1 in order. When `tail_agn` is 0, or for the element-result operations, no index at or above vl is written.
- R10: `done` pulses for exactly one cycle, in the cycle after the last write, or two cycles after start when nothing is written. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | 32 | Instruction word |
| sew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| lmul | input | 3 | Grouping code; 1..3 mean 2, 4, 8 registers |
| vl | input | IDXW (9) | Active vector length |
| vlmax | input | IDXW (9) | Maximum element count for this width and grouping |
| tail_agn | input | 1 | Tail-agnostic flag |
| scalar | input | ELEN (64) | Scalar operand |
| elem_idx | output | IDXW (9) | Element being read and written |
| vs2_elem | input | ELEN (64) | vs2 element at `elem_idx` |
| vs1_elem | input | ELEN (64) | vs1 element at `elem_idx` |
| v0_bit | input | 1 | Bit `elem_idx` of v0 |
| wr_en | output | 1 | Write strobe for `elem_idx` |
| wr_is_mask | output | 1 | Write targets a mask bit rather than an element |
| wr_data | output | ELEN (64) | Result element |
| wr_bit | output | 1 | Destination mask bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was due to an illegal instruction |

## Verification
Random element data is run at every width, with per-element v0 bits, so that carry-in and borrow-in flips are visible element by element. Directed all-ones and equal-operand cases separate a wrapping sum from a sum that merely equals vs2, and "<" from "<=". Scalar values with high bits set and negative immediates show truncation and sign extension. Both settings of vm on the mask operations show whether v0 is used, both tail settings with vl below vlmax show the tail sweep, and vl of zero plus a start pulse during a run test the sequencing edges. Illegal encodings cover vm=1, v0 as destination under grouping, subtract with an immediate, and an unknown operation code.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

    localparam logic [6:0] OPC_VARITH = 7'b1010111;

    localparam logic [5:0] F6_ADD_C   = 6'b010000;
    localparam logic [5:0] F6_ADD_CO  = 6'b010001;
    localparam logic [5:0] F6_SUB_B   = 6'b010010;
    localparam logic [5:0] F6_SUB_BO  = 6'b010011;

    localparam logic [2:0] F3_VV = 3'b000;
    localparam logic [2:0] F3_VX = 3'b100;
    localparam logic [2:0] F3_VI = 3'b011;

    typedef enum logic [1:0] {
        OP_ADD_C,
        OP_ADD_CO,
        OP_SUB_B,
        OP_SUB_BO
    } vcb_op_e;

    typedef enum logic [1:0] {
        SRC_VEC,
        SRC_SCALAR,
        SRC_IMM
    } vcb_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_DONE
    } vcb_state_e;

    typedef struct packed {
        vcb_op_e    op;
        vcb_src_e   src;
        logic       vm;
        logic [4:0] vd;
        logic [4:0] imm;
    } vcb_dec_t;

endpackage

// File: rtl/vcb_decode.sv
module vcb_decode
    import vcb_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [2:0]  lmul,
    output vcb_dec_t    dec,
    output logic        bad
);

    logic [5:0] f6;
    logic [2:0] f3;
    logic       op_known;
    logic       src_known;
    logic       grouped;
    logic       body_op;

    always_comb begin
        f6        = instr[31:26];
        f3        = instr[14:12];
        dec.vm    = instr[25];
        dec.vd    = instr[11:7];
        dec.imm   = instr[19:15];
        op_known  = 1'b1;
        src_known = 1'b1;
        dec.op    = OP_ADD_C;
        dec.src   = SRC_VEC;

        unique case (f6)
            F6_ADD_C:  dec.op = OP_ADD_C;
            F6_ADD_CO: dec.op = OP_ADD_CO;
            F6_SUB_B:  dec.op = OP_SUB_B;
            F6_SUB_BO: dec.op = OP_SUB_BO;
            default:   op_known = 1'b0;
        endcase

        unique case (f3)
            F3_VV:   dec.src = SRC_VEC;
            F3_VX:   dec.src = SRC_SCALAR;
            F3_VI:   dec.src = SRC_IMM;
            default: src_known = 1'b0;
        endcase

        grouped = (lmul == 3'd1) || (lmul == 3'd2) || (lmul == 3'd3);
        body_op = (dec.op == OP_ADD_C) || (dec.op == OP_SUB_B);

        bad = (instr[6:0] != OPC_VARITH)
            || !op_known
            || !src_known
            || ((dec.src == SRC_IMM) && ((dec.op == OP_SUB_B) || (dec.op == OP_SUB_BO)))
            || (body_op && dec.vm)
            || (body_op && (dec.vd == 5'd0) && grouped);
    end

endmodule

// File: rtl/vcb_alu.sv
module vcb_alu #(
    parameter int ELEN = 64
) (
    input  logic [ELEN-1:0] a,
    input  logic [ELEN-1:0] b,
    input  logic            cin,
    input  logic            is_sub,
    input  logic [1:0]      sew,
    output logic [ELEN-1:0] res,
    output logic            cout
);

    localparam int NW = $clog2(ELEN / 8) + 1;

    logic [ELEN-1:0] res_l [NW];
    logic [NW-1:0]   co_l;

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W:0] add_f;
        logic [W:0] sub_f;

        assign add_f = {1'b0, a[W-1:0]} + {1'b0, b[W-1:0]} + {{W{1'b0}}, cin};
        assign sub_f = {1'b0, a[W-1:0]} - {1'b0, b[W-1:0]} - {{W{1'b0}}, cin};

        assign res_l[g] = is_sub ? ELEN'(sub_f[W-1:0]) : ELEN'(add_f[W-1:0]);
        assign co_l[g]  = is_sub ? sub_f[W] : add_f[W];
    end

    always_comb begin
        res  = '0;
        cout = 1'b0;
        for (int k = 0; k < NW; k++) begin
            if (int'(sew) == k) begin
                res  = res_l[k];
                cout = co_l[k];
            end
        end
    end

endmodule

// File: rtl/vec_carry_unit.sv
module vec_carry_unit
    import vcb_pkg::*;
#(
    parameter int ELEN   = 64,
    parameter int MAX_VL = 256,
    localparam int IDXW  = $clog2(MAX_VL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    input  logic [1:0]      sew,
    input  logic [2:0]      lmul,
    input  logic [IDXW-1:0] vl,
    input  logic [IDXW-1:0] vlmax,
    input  logic            tail_agn,
    input  logic [ELEN-1:0] scalar,
    output logic [IDXW-1:0] elem_idx,
    input  logic [ELEN-1:0] vs2_elem,
    input  logic [ELEN-1:0] vs1_elem,
    input  logic            v0_bit,
    output logic            wr_en,
    output logic            wr_is_mask,
    output logic [ELEN-1:0] wr_data,
    output logic            wr_bit,
    output logic            busy,
    output logic            done,
    output logic            illegal
);

    vcb_state_e      st_q, st_d;
    logic [IDXW-1:0] idx_q, idx_d;
    vcb_dec_t        dec_in, dec_q;
    logic            bad_in, bad_q;
    logic [IDXW-1:0] vl_q, vlmax_q;
    logic [1:0]      sew_q;
    logic            ta_q;
    logic [ELEN-1:0] scalar_q;

    logic            mask_in, mask_q;
    logic            sweep_in, sweep_q;
    logic            last_body, last_tail;
    logic [ELEN-1:0] op1;
    logic            cin;
    logic [ELEN-1:0] alu_res;
    logic            alu_co;

    vcb_decode u_decode (
        .instr (instr),
        .lmul  (lmul),
        .dec   (dec_in),
        .bad   (bad_in)
    );

    assign mask_in  = (dec_in.op == OP_ADD_CO) || (dec_in.op == OP_SUB_BO);
    assign mask_q   = (dec_q.op == OP_ADD_CO) || (dec_q.op == OP_SUB_BO);
    assign sweep_in = mask_in && tail_agn && (vl < vlmax);
    assign sweep_q  = mask_q && ta_q && (vl_q < vlmax_q);

    assign last_body = (idx_q == vl_q - 1'b1);
    assign last_tail = (idx_q == vlmax_q - 1'b1);

    // Operand selection and carry-in policy
    always_comb begin
        unique case (dec_q.src)
            SRC_VEC:    op1 = vs1_elem;
            SRC_SCALAR: op1 = scalar_q;
            default:    op1 = {{(ELEN-5){dec_q.imm[4]}}, dec_q.imm};
        endcase
        cin = (mask_q && dec_q.vm) ? 1'b0 : v0_bit;
    end

    vcb_alu #(.ELEN(ELEN)) u_alu (
        .a      (vs2_elem),
        .b      (op1),
        .cin    (cin),
        .is_sub ((dec_q.op == OP_SUB_B) || (dec_q.op == OP_SUB_BO)),
        .sew    (sew_q),
        .res    (alu_res),
        .cout   (alu_co)
    );

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                idx_d = '0;
                if (start) begin
                    if (bad_in)              st_d = ST_DONE;
                    else if (vl != '0)       st_d = ST_RUN;
                    else if (sweep_in)       st_d = ST_TAIL;
                    else                     st_d = ST_DONE;
                end
            end
            ST_RUN: begin
                idx_d = idx_q + 1'b1;
                if (last_body) st_d = sweep_q ? ST_TAIL : ST_DONE;
            end
            ST_TAIL: begin
                idx_d = idx_q + 1'b1;
                if (last_tail) st_d = ST_DONE;
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register and captured operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            dec_q    <= '0;
            bad_q    <= 1'b0;
            vl_q     <= '0;
            vlmax_q  <= '0;
            sew_q    <= '0;
            ta_q     <= 1'b0;
            scalar_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            if (st_q == ST_IDLE && start) begin
                dec_q    <= dec_in;
                bad_q    <= bad_in;
                vl_q     <= vl;
                vlmax_q  <= vlmax;
                sew_q    <= sew;
                ta_q     <= tail_agn;
                scalar_q <= scalar;
            end
        end
    end

    // Outputs
    always_comb begin
        elem_idx   = idx_q;
        busy       = (st_q != ST_IDLE);
        done       = (st_q == ST_DONE);
        illegal    = (st_q == ST_DONE) && bad_q;
        wr_en      = 1'b0;
        wr_is_mask = 1'b0;
        wr_data    = '0;
        wr_bit     = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                wr_en      = 1'b1;
                wr_is_mask = mask_q;
                wr_data    = mask_q ? '0 : alu_res;
                wr_bit     = mask_q ? alu_co : 1'b0;
            end
            ST_TAIL: begin
                wr_en      = 1'b1;
                wr_is_mask = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: every write happens inside a busy window
    p_wr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R8: back-to-back writes step the index by one
    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (elem_idx == $past(elem_idx) + 1'b1));

    // R9: writes at or past vl are zero mask bits
    p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (elem_idx >= vl_q)) |-> (wr_is_mask && !wr_bit));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an illegal completion carries no write
    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wr_en));

    // R3: element results never leave bits above SEW set
    p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_mask && (sew_q == 2'd0)) |-> (wr_data[ELEN-1:8] == '0));

endmodule

// File: tb/tb_vec_carry_unit.sv
module tb_vec_carry_unit;

    localparam int ELEN = 64;
    localparam int IDXW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     instr = '0;
    logic [1:0]      sew = '0;
    logic [2:0]      lmul = '0;
    logic [IDXW-1:0] vl = '0;
    logic [IDXW-1:0] vlmax = '0;
    logic            tail_agn = 1'b0;
    logic [ELEN-1:0] scalar = '0;
    logic [IDXW-1:0] elem_idx;
    logic [ELEN-1:0] vs2_elem, vs1_elem;
    logic            v0_bit;
    logic            wr_en, wr_is_mask, wr_bit, busy, done, illegal;
    logic [ELEN-1:0] wr_data;

    logic [63:0] vs2_m [256];
    logic [63:0] vs1_m [256];
    logic        v0_m  [256];

    assign vs2_elem = vs2_m[elem_idx[7:0]];
    assign vs1_elem = vs1_m[elem_idx[7:0]];
    assign v0_bit   = v0_m[elem_idx[7:0]];

    always #2 clk = ~clk;

    vec_carry_unit #(.ELEN(ELEN), .MAX_VL(256)) dut (
        .clk, .rst_n, .start, .instr, .sew, .lmul, .vl, .vlmax, .tail_agn,
        .scalar, .elem_idx, .vs2_elem, .vs1_elem, .v0_bit, .wr_en,
        .wr_is_mask, .wr_data, .wr_bit, .busy, .done, .illegal
    );

    typedef struct {
        int          idx;
        bit          m;
        logic [63:0] d;
        bit          b;
        string       tag;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] f6, input bit vm,
                                       input logic [4:0] rs1, input logic [2:0] f3,
                                       input logic [4:0] vd);
        return {f6, vm, 5'd8, rs1, f3, vd, 7'b1010111};
    endfunction

    // Monitor: compare every write with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8", "unexpected write idx", 64'(elem_idx), 64'hx);
            end else begin
                item_t e;
                e = q.pop_front();
                chk(elem_idx == IDXW'(e.idx), e.tag, "index", 64'(elem_idx), 64'(e.idx));
                chk(wr_is_mask == e.m, e.tag, "mask flag", 64'(wr_is_mask), 64'(e.m));
                if (e.m) chk(wr_bit == e.b, e.tag, "mask bit", 64'(wr_bit), 64'(e.b));
                else     chk(wr_data == e.d, e.tag, "element", wr_data, e.d);
            end
        end
    end

    task automatic run_op(input string tag, input logic [31:0] ins, input logic [1:0] s,
                          input int n_vl, input int n_max, input logic [2:0] lm,
                          input bit ta, input logic [63:0] sc, input bit exp_bad,
                          input bit poke);
        int w;
        logic [63:0] msk, a, b, r;
        bit c, vm, is_mask;
        logic [5:0] f6;
        logic [2:0] f3;
        int guard;
        f6 = ins[31:26];
        f3 = ins[14:12];
        vm = ins[25];
        is_mask = (f6 == 6'b010001) || (f6 == 6'b010011);
        w = 8 << s;
        msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        if (!exp_bad) begin
            for (int i = 0; i < n_vl; i++) begin
                item_t e;
                a = vs2_m[i] & msk;
                if (f3 == 3'b000)      b = vs1_m[i] & msk;
                else if (f3 == 3'b100) b = sc & msk;
                else                   b = {{59{ins[19]}}, ins[19:15]} & msk;
                c = (is_mask && vm) ? 1'b0 : v0_m[i];
                e.idx = i; e.m = is_mask; e.d = '0; e.b = 1'b0; e.tag = tag;
                unique case (f6)
                    6'b010000: e.d = (a + b + 64'(c)) & msk;
                    6'b010010: e.d = (a - b - 64'(c)) & msk;
                    6'b010001: begin
                        r = (a + b + 64'(c)) & msk;
                        e.b = (r < a) || (c && (r == a));
                    end
                    default: e.b = c ? (a <= b) : (a < b);
                endcase
                q.push_back(e);
            end
            if (is_mask && ta) begin
                for (int i = n_vl; i < n_max; i++) begin
                    item_t e;
                    e.idx = i; e.m = 1'b1; e.d = '0; e.b = 1'b0; e.tag = "R9";
                    q.push_back(e);
                end
            end
        end
        @(negedge clk);
        instr = ins; sew = s; vl = IDXW'(n_vl); vlmax = IDXW'(n_max);
        lmul = lm; tail_agn = ta; scalar = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            chk(busy == 1'b1, "R8", "busy during run", 64'(busy), 64'd1);
            instr = mk(6'b010010, 1'b0, 5'd1, 3'b000, 5'd3);
            vl = 9'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 600) begin
            @(negedge clk);
            guard++;
        end
        #1;
        chk(done == 1'b1, "R10", "done reached", 64'(done), 64'd1);
        chk(q.size() == 0, exp_bad ? "R6" : "R8", "writes missing",
            64'(q.size()), 64'd0);
        chk(illegal == exp_bad, exp_bad ? "R6" : "R1", "illegal flag",
            64'(illegal), 64'(exp_bad));
        q.delete();
        @(negedge clk);
        chk(!done && !busy, "R10", "done single cycle", 64'({done, busy}), 64'd0);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 256; i++) begin
            vs2_m[i] = {$urandom, $urandom};
            vs1_m[i] = {$urandom, $urandom};
            v0_m[i]  = 1'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        fill_rand();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en && !illegal, "R10", "reset outputs",
            64'({busy, done, wr_en, illegal}), 64'd0);
        rst_n = 1'b1;

        // R2 add-with-carry, vector-vector at 8 and 64 bits
        run_op("R2", mk(6'b010000, 1'b0, 5'd0, 3'b000, 5'd4), 2'd0, 10, 16, 3'd0, 1'b1, 0, 1'b0, 1'b0);
        run_op("R2", mk(6'b010000, 1'b0, 5'd0, 3'b000, 5'd4), 2'd3, 6, 8, 3'd1, 1'b1, 0, 1'b0, 1'b0);
        // R3 subtract-with-borrow at 16 and 32 bits
        run_op("R3", mk(6'b010010, 1'b0, 5'd0, 3'b000, 5'd5), 2'd1, 9, 16, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        run_op("R3", mk(6'b010010, 1'b0, 5'd0, 3'b100, 5'd5), 2'd2, 7, 8, 3'd0, 1'b0, 64'hFFFF_0000_8000_0001, 1'b0, 1'b0);
        // R4 carry-out with v0 and tail sweep (R9)
        run_op("R4", mk(6'b010001, 1'b0, 5'd0, 3'b000, 5'd6), 2'd2, 5, 12, 3'd0, 1'b1, 0, 1'b0, 1'b0);
        // R4 edge: all-ones plus zero with carry-in, vm=0 vs vm=1
        for (int i = 0; i < 8; i++) begin
            vs2_m[i] = 64'hFF; vs1_m[i] = (i < 4) ? 64'h0 : 64'h1; v0_m[i] = 1'b1;
        end
        run_op("R4", mk(6'b010001, 1'b0, 5'd0, 3'b000, 5'd6), 2'd0, 8, 8, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        run_op("R4", mk(6'b010001, 1'b1, 5'd0, 3'b000, 5'd6), 2'd0, 8, 8, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        // R5 borrow-out: equal operands separate < from <=
        for (int i = 0; i < 8; i++) begin
            vs2_m[i] = 64'h1234; vs1_m[i] = (i < 4) ? 64'h1234 : 64'h1235; v0_m[i] = i[0];
        end
        run_op("R5", mk(6'b010011, 1'b0, 5'd0, 3'b000, 5'd7), 2'd1, 8, 16, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        run_op("R5", mk(6'b010011, 1'b1, 5'd0, 3'b000, 5'd7), 2'd1, 8, 8, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        fill_rand();
        // R5 scalar form at 64 bits, tail undisturbed (R9)
        run_op("R5", mk(6'b010011, 1'b0, 5'd0, 3'b100, 5'd7), 2'd3, 6, 10, 3'd0, 1'b0, {$urandom, $urandom}, 1'b0, 1'b0);
        // R7 scalar truncation and immediate sign extension
        run_op("R7", mk(6'b010000, 1'b0, 5'd0, 3'b100, 5'd4), 2'd0, 8, 8, 3'd0, 1'b0, 64'hABCD_EF01_2345_67F0, 1'b0, 1'b0);
        run_op("R7", mk(6'b010000, 1'b0, 5'b10011, 3'b011, 5'd4), 2'd1, 8, 8, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        run_op("R7", mk(6'b010001, 1'b1, 5'b11111, 3'b011, 5'd6), 2'd3, 5, 8, 3'd0, 1'b1, 0, 1'b0, 1'b0);
        // R1 decode rejects: subtract with immediate, unknown op, bad form
        run_op("R1", mk(6'b010010, 1'b0, 5'd1, 3'b011, 5'd4), 2'd0, 4, 8, 3'd0, 1'b0, 0, 1'b1, 1'b0);
        run_op("R1", mk(6'b010111, 1'b0, 5'd1, 3'b000, 5'd4), 2'd0, 4, 8, 3'd0, 1'b0, 0, 1'b1, 1'b0);
        run_op("R1", mk(6'b010000, 1'b0, 5'd1, 3'b001, 5'd4), 2'd0, 4, 8, 3'd0, 1'b0, 0, 1'b1, 1'b0);
        // R6 vm=1 on body ops, v0 destination with grouping
        run_op("R6", mk(6'b010000, 1'b1, 5'd0, 3'b000, 5'd4), 2'd0, 4, 8, 3'd0, 1'b0, 0, 1'b1, 1'b0);
        run_op("R6", mk(6'b010010, 1'b0, 5'd0, 3'b000, 5'd0), 2'd0, 4, 8, 3'd2, 1'b0, 0, 1'b1, 1'b0);
        run_op("R6", mk(6'b010000, 1'b0, 5'd0, 3'b000, 5'd0), 2'd0, 4, 8, 3'd0, 1'b0, 0, 1'b0, 1'b0);
        // R9 vl of zero: mask op sweeps tail, body op writes nothing
        run_op("R9", mk(6'b010001, 1'b0, 5'd0, 3'b000, 5'd6), 2'd0, 0, 5, 3'd0, 1'b1, 0, 1'b0, 1'b0);
        run_op("R9", mk(6'b010000, 1'b0, 5'd0, 3'b000, 5'd4), 2'd0, 0, 5, 3'd0, 1'b1, 0, 1'b0, 1'b0);
        // R10 start pulse during a run is ignored
        run_op("R10", mk(6'b010000, 1'b0, 5'd0, 3'b000, 5'd4), 2'd2, 6, 8, 3'd0, 1'b0, 0, 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule